// File: doc/BRIEF.md
# Selectable adjacent-burst ECC codec

This block protects one 64-bit memory word with 11 check bits, forming a 75-bit stored codeword. The write path takes a data word and returns the codeword to be stored. The read path takes a stored codeword and returns the data word, a record of what was repaired, and a flag for damage it could not repair. Both paths are single-stage: each result is registered on the first rising clock edge after its inputs are applied.

The code is built to repair bursts of neighbouring flipped bits, such as those one particle strike leaves in dense storage. A 2-bit depth input sets how aggressive the repair is: off, single bits only, bursts of up to two neighbours, or bursts of up to three neighbours. Longer bursts of four to eight neighbours are always reported as unrepairable and are never miscorrected. In single-bit depth the code also behaves as a classic single-correct, double-detect code for any two flipped bits.

Codeword layout: bits [63:0] hold the data unchanged, and bits [74:64] hold the check bits. Position 0 is the lowest bit, and a burst of length L starting at position p covers positions p through p+L-1.

Top module: `adburst_ecc`

## Requirements
- R1: `wr_code[63:0]` equals the `wr_data` applied before the previous rising edge. A codeword produced this way reads back as error-free in every depth.
- R2: A read of an unmodified codeword, at any depth, returns the original data with `rd_uncorr` low and `rd_fix` zero.
- R3: With depth 0 (off), every flipped pattern of 1, 2 or 3 neighbouring bits raises `rd_uncorr`, and no repair is made.
- R4: With depth 1, a single flipped bit at any of the 75 positions is repaired.
- R5: With depth 1, any two flipped bits, whether neighbours or far apart, raise `rd_uncorr`.
- R6: With depth 2, single flips and 2-bit neighbouring bursts at every start are repaired, and every 3-bit burst raises `rd_uncorr`.
- R7: With depth 3, bursts of 1, 2 and 3 neighbouring bits at every start position are repaired.
- R8: At every depth, any burst of 4 to 8 neighbouring bits at any start raises `rd_uncorr`.
- R9: `rd_fix` is {length[8:7], start[6:0]} of the repaired burst. It is zero whenever nothing was repaired, including when `rd_uncorr` is high.
- R10: When `rd_uncorr` is high, `rd_data` equals bits [63:0] of the received codeword, unmodified.
- R11: While reset is held, `wr_code`, `rd_data` and `rd_fix` are zero and `rd_uncorr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Repair depth: 0 off, 1 single bit, 2 up to two neighbours, 3 up to three neighbours |
| wr_data | input | 64 | Data word to encode |
| wr_code | output | 75 | Encoded codeword: data in [63:0], check bits in [74:64] |
| rd_code | input | 75 | Codeword read back from storage |
| rd_data | output | 64 | Repaired data, or raw data when unrepairable |
| rd_fix | output | 9 | Burst length [8:7] and start position [6:0] of the repair |
| rd_uncorr | output | 1 | Damage detected that the current depth cannot repair |

## Verification
Every result is due exactly one rising edge after its stimulus. `wr_code` follows `wr_data`, and the three read outputs follow `rd_code` together with `mode` sampled at the same edge. The bench changes inputs on a falling edge and reads the outputs on the next falling edge, so exactly one rising edge separates stimulus and observation. Every sweep re-drives both the codeword and the depth on each read, so no result depends on the previous one.

// File: rtl/adburst_pkg.sv
package adburst_pkg;

  localparam int DATA_W    = 64;
  localparam int RES_W     = 7;            // residue (position mod RES_W) one-hot field
  localparam int GF_W      = 4;            // GF(2^GF_W) position field
  localparam logic [GF_W-1:0] GF_POLY = 4'b0011;  // x^4 = x + 1
  localparam int CHK_W     = RES_W + GF_W;
  localparam int CODE_W    = DATA_W + CHK_W;
  localparam int MAX_BURST = 3;
  localparam int LEN_W     = $clog2(MAX_BURST + 1);
  localparam int POS_W     = $clog2(CODE_W);
  localparam int FIX_W     = LEN_W + POS_W;
  localparam int HIT_W     = MAX_BURST * CODE_W;

  typedef logic [CHK_W-1:0] syn_t;

  typedef enum logic [LEN_W-1:0] {
    DEPTH_OFF    = 2'd0,
    DEPTH_SINGLE = 2'd1,
    DEPTH_PAIR   = 2'd2,
    DEPTH_TRIPLE = 2'd3
  } depth_e;

  // Parity-check column of codeword position idx:
  // {alpha^idx in GF(16), one-hot of idx mod RES_W}
  function automatic syn_t h_col(input int idx);
    logic [GF_W-1:0]  g;
    logic [RES_W-1:0] r;
    g = GF_W'(1);
    for (int k = 0; k < idx; k++)
      g = {g[GF_W-2:0], 1'b0} ^ (g[GF_W-1] ? GF_POLY : '0);
    r = '0;
    r[idx % RES_W] = 1'b1;
    return {g, r};
  endfunction

  function automatic logic [CODE_W-1:0][CHK_W-1:0] build_h();
    logic [CODE_W-1:0][CHK_W-1:0] t;
    for (int i = 0; i < CODE_W; i++) t[i] = h_col(i);
    return t;
  endfunction

  // Syndrome produced by a burst of len flipped bits starting at start
  function automatic syn_t burst_syn(input int start, input int len);
    syn_t acc;
    acc = '0;
    for (int i = 0; i < len; i++) acc ^= h_col(start + i);
    return acc;
  endfunction

  // Inverse of the square matrix formed by the check-bit columns, by
  // Gauss-Jordan elimination over GF(2). Row r of the result gives check
  // bit r as a parity over the data-part syndrome.
  function automatic logic [CHK_W-1:0][CHK_W-1:0] enc_inverse();
    logic [CHK_W-1:0][2*CHK_W-1:0] a;
    logic [2*CHK_W-1:0]            tmp;
    logic [CHK_W-1:0][CHK_W-1:0]   inv;
    syn_t                          c;
    int                            piv;
    for (int r = 0; r < CHK_W; r++) begin
      a[r] = '0;
      a[r][CHK_W + r] = 1'b1;
    end
    for (int k = 0; k < CHK_W; k++) begin
      c = h_col(DATA_W + k);
      for (int r = 0; r < CHK_W; r++) a[r][k] = c[r];
    end
    for (int p = 0; p < CHK_W; p++) begin
      piv = -1;
      for (int q = p; q < CHK_W; q++)
        if (piv < 0 && a[q][p]) piv = q;
      if (piv >= 0) begin
        tmp    = a[p];
        a[p]   = a[piv];
        a[piv] = tmp;
        for (int q = 0; q < CHK_W; q++)
          if (q != p && a[q][p]) a[q] ^= a[p];
      end
    end
    for (int r = 0; r < CHK_W; r++) inv[r] = a[r][2*CHK_W-1:CHK_W];
    return inv;
  endfunction

endpackage

// File: rtl/adburst_syndrome.sv
module adburst_syndrome
  import adburst_pkg::*;
(
  input  logic [CODE_W-1:0] word,
  output syn_t              syn
);

  localparam logic [CODE_W-1:0][CHK_W-1:0] H_TAB = build_h();

  always_comb begin
    syn = '0;
    for (int i = 0; i < CODE_W; i++)
      if (word[i]) syn ^= H_TAB[i];
  end

endmodule

// File: rtl/adburst_encoder.sv
module adburst_encoder
  import adburst_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);

  localparam logic [CHK_W-1:0][CHK_W-1:0] ENC_INV = enc_inverse();

  syn_t data_syn;

  adburst_syndrome u_dsyn (
    .word ({{CHK_W{1'b0}}, data}),
    .syn  (data_syn)
  );

  // Check bits c satisfy H_chk * c = H_data * d, so the full syndrome is zero
  always_comb begin
    for (int r = 0; r < CHK_W; r++)
      check[r] = ^(ENC_INV[r] & data_syn);
  end

endmodule

// File: rtl/adburst_locator.sv
module adburst_locator
  import adburst_pkg::*;
(
  input  syn_t              syn,
  input  logic [LEN_W-1:0]  depth,
  output logic [HIT_W-1:0]  hit_vec,
  output logic [DATA_W-1:0] flip,
  output logic [FIX_W-1:0]  fix,
  output logic              located
);

  // One comparator per (length, start) pair; only lengths within depth match
  for (genvar L = 1; L <= MAX_BURST; L++) begin : g_len
    logic allow;
    assign allow = (depth >= LEN_W'(L));
    for (genvar s = 0; s < CODE_W; s++) begin : g_pos
      if (s + L <= CODE_W) begin : g_on
        localparam syn_t PATTERN = burst_syn(s, L);
        assign hit_vec[(L-1)*CODE_W + s] = allow && (syn == PATTERN);
      end else begin : g_off
        assign hit_vec[(L-1)*CODE_W + s] = 1'b0;
      end
    end
  end

  always_comb begin
    flip = '0;
    fix  = '0;
    for (int L = 1; L <= MAX_BURST; L++) begin
      for (int s = 0; s < CODE_W; s++) begin
        if (hit_vec[(L-1)*CODE_W + s]) begin
          for (int b = 0; b < MAX_BURST; b++)
            if (b < L && s + b < DATA_W) flip[s + b] = 1'b1;
          fix = fix | {LEN_W'(L), POS_W'(s)};
        end
      end
    end
  end

  assign located = |hit_vec;

endmodule

// File: rtl/adburst_ecc.sv
module adburst_ecc
  import adburst_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [CODE_W-1:0]       wr_code,
  input  logic [CODE_W-1:0]       rd_code,
  output logic [DATA_W-1:0]       rd_data,
  output logic [FIX_W-1:0]        rd_fix,
  output logic                    rd_uncorr
);

  // Write path
  logic [CHK_W-1:0] enc_check;

  adburst_encoder u_enc (
    .data  (wr_data),
    .check (enc_check)
  );

  // Read path: internal events named for the checker
  syn_t              rd_syn;
  logic [HIT_W-1:0]  hit_vec;
  logic [DATA_W-1:0] dec_flip;
  logic [FIX_W-1:0]  dec_fix;
  logic              dec_located;
  logic              dec_uncorr;
  logic [DATA_W-1:0] dec_data;

  adburst_syndrome u_rsyn (
    .word (rd_code),
    .syn  (rd_syn)
  );

  adburst_locator u_loc (
    .syn     (rd_syn),
    .depth   (mode),
    .hit_vec (hit_vec),
    .flip    (dec_flip),
    .fix     (dec_fix),
    .located (dec_located)
  );

  assign dec_uncorr = (rd_syn != '0) && !dec_located;
  assign dec_data   = dec_uncorr ? rd_code[DATA_W-1:0]
                                 : (rd_code[DATA_W-1:0] ^ dec_flip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_code   <= '0;
      rd_data   <= '0;
      rd_fix    <= '0;
      rd_uncorr <= 1'b0;
    end else begin
      wr_code   <= {enc_check, wr_data};
      rd_data   <= dec_data;
      rd_fix    <= dec_located ? dec_fix : '0;
      rd_uncorr <= dec_uncorr;
    end
  end

endmodule

// File: rtl/adburst_ecc_chk.sv
module adburst_ecc_chk
  import adburst_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [DATA_W-1:0] wr_data,
  input logic [CODE_W-1:0] wr_code,
  input logic [CODE_W-1:0] rd_code,
  input logic [DATA_W-1:0] rd_data,
  input logic [FIX_W-1:0]  rd_fix,
  input logic              rd_uncorr,
  input syn_t              rd_syn,
  input logic [HIT_W-1:0]  hit_vec
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_WR_DATA_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> wr_code[DATA_W-1:0] == $past(wr_data)); // R1

  AST_CLEAN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(rd_syn) == '0) |-> (!rd_uncorr && rd_fix == '0 && rd_data == $past(rd_code[DATA_W-1:0]))); // R2

  AST_OFF_NO_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(mode) == 2'd0) |-> (rd_fix == '0 && rd_data == $past(rd_code[DATA_W-1:0]))); // R3

  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R7

  AST_LEN_WITHIN_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> rd_fix[FIX_W-1:POS_W] <= $past(mode)); // R6

  AST_FIX_ZERO_ON_UE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_uncorr |-> rd_fix == '0); // R9

  AST_UE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    rd_uncorr |-> rd_data == $past(rd_code[DATA_W-1:0])); // R10

endmodule

bind adburst_ecc adburst_ecc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .wr_data   (wr_data),
  .wr_code   (wr_code),
  .rd_code   (rd_code),
  .rd_data   (rd_data),
  .rd_fix    (rd_fix),
  .rd_uncorr (rd_uncorr),
  .rd_syn    (rd_syn),
  .hit_vec   (hit_vec)
);

// File: tb/tb_adburst_ecc.sv
module tb_adburst_ecc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [63:0] wr_data = '0;
  logic [74:0] wr_code;
  logic [74:0] rd_code = '0;
  logic [63:0] rd_data;
  logic [8:0]  rd_fix;
  logic        rd_uncorr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [63:0] d_tab [4];
  logic [74:0] c_tab [4];

  always #2 clk = ~clk;

  adburst_ecc dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .wr_data   (wr_data),
    .wr_code   (wr_code),
    .rd_code   (rd_code),
    .rd_data   (rd_data),
    .rd_fix    (rd_fix),
    .rd_uncorr (rd_uncorr)
  );

  function automatic logic [74:0] burst(input int s, input int len);
    logic [74:0] m;
    m = '0;
    for (int i = 0; i < len; i++)
      if (s + i < 75) m[s + i] = 1'b1;
    return m;
  endfunction

  function automatic logic [8:0] fixval(input int s, input int len);
    return {len[1:0], s[6:0]};
  endfunction

  // Drive a read on a falling edge, sample on the next falling edge
  task automatic read_check(input string tag, input logic [74:0] code, input logic [1:0] m,
                            input logic [63:0] exp_d, input logic exp_ue, input logic [8:0] exp_fix);
    @(negedge clk);
    rd_code = code;
    mode    = m;
    @(negedge clk);
    n_chk++;
    if (rd_data !== exp_d || rd_uncorr !== exp_ue || rd_fix !== exp_fix) begin
      n_fail++;
      $display("FAIL %s: mode=%0d data=%h ue=%b fix=%h expected data=%h ue=%b fix=%h",
               tag, m, rd_data, rd_uncorr, rd_fix, exp_d, exp_ue, exp_fix);
    end
  endtask

  task automatic t_reset();
    n_chk++;
    if (wr_code !== '0 || rd_data !== '0 || rd_fix !== '0 || rd_uncorr !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: wr_code=%h data=%h fix=%h ue=%b expected all zero",
               wr_code, rd_data, rd_fix, rd_uncorr);
    end
  endtask

  // R1 encode and R2 clean read-back
  task automatic t_encode();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      wr_data = d_tab[k];
      @(negedge clk);
      c_tab[k] = wr_code;
      n_chk++;
      if (wr_code[63:0] !== d_tab[k]) begin
        n_fail++;
        $display("FAIL R1: wr_code[63:0]=%h expected %h", wr_code[63:0], d_tab[k]);
      end
      for (int m = 0; m < 4; m++)
        read_check("R2", c_tab[k], 2'(m), d_tab[k], 1'b0, 9'd0);
    end
  endtask

  // R3 depth off: everything flagged, raw data back (R10)
  task automatic t_depth_off();
    for (int len = 1; len <= 3; len++)
      for (int s = 0; s + len <= 75; s += 3) begin
        logic [74:0] bad;
        bad = c_tab[s % 4] ^ burst(s, len);
        read_check("R3", bad, 2'd0, bad[63:0], 1'b1, 9'd0);
      end
  endtask

  // R4 singles repaired, R5 any two flips flagged, R9 report
  task automatic t_depth_single();
    for (int s = 0; s < 75; s++)
      read_check("R4", c_tab[s % 4] ^ burst(s, 1), 2'd1, d_tab[s % 4], 1'b0, fixval(s, 1));
    for (int i = 0; i < 75; i++)
      for (int k = 0; k < 4; k++) begin
        int gap;
        gap = (k == 0) ? 1 : (k == 1) ? 7 : (k == 2) ? 15 : 37;
        if (i + gap < 75) begin
          logic [74:0] bad;
          bad = c_tab[i % 4] ^ burst(i, 1) ^ burst(i + gap, 1);
          read_check("R5", bad, 2'd1, bad[63:0], 1'b1, 9'd0);
        end
      end
  endtask

  // R6 depth two: pairs repaired, triples flagged
  task automatic t_depth_pair();
    for (int s = 0; s < 75; s += 4)
      read_check("R6", c_tab[s % 4] ^ burst(s, 1), 2'd2, d_tab[s % 4], 1'b0, fixval(s, 1));
    for (int s = 0; s + 2 <= 75; s++)
      read_check("R6", c_tab[s % 4] ^ burst(s, 2), 2'd2, d_tab[s % 4], 1'b0, fixval(s, 2));
    for (int s = 0; s + 3 <= 75; s++) begin
      logic [74:0] bad;
      bad = c_tab[s % 4] ^ burst(s, 3);
      read_check("R6", bad, 2'd2, bad[63:0], 1'b1, 9'd0);
    end
  endtask

  // R7 depth three: every 1-, 2-, 3-bit burst repaired
  task automatic t_depth_triple();
    for (int len = 1; len <= 3; len++)
      for (int s = 0; s + len <= 75; s++)
        read_check("R7", c_tab[(s + len) % 4] ^ burst(s, len), 2'd3,
                   d_tab[(s + len) % 4], 1'b0, fixval(s, len));
  endtask

  // R8 long bursts flagged at every depth, raw data back (R10)
  task automatic t_long_bursts();
    for (int m = 0; m < 4; m++)
      for (int len = 4; len <= 8; len++)
        for (int s = 0; s + len <= 75; s++) begin
          logic [74:0] bad;
          bad = c_tab[s % 4] ^ burst(s, len);
          read_check("R8", bad, 2'(m), bad[63:0], 1'b1, 9'd0);
        end
  endtask

  initial begin
    d_tab[0] = 64'h0000_0000_0000_0000;
    d_tab[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    d_tab[2] = 64'h0123_4567_89AB_CDEF;
    d_tab[3] = 64'h9E37_79B9_7F4A_7C15;
    wr_data  = 64'h5555_AAAA_3333_CCCC;
    rd_code  = {11'h5A5, 64'hFFFF_0000_FFFF_0000};
    mode     = 2'd3;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_encode();
    t_depth_off();
    t_depth_single();
    t_depth_pair();
    t_depth_triple();
    t_long_bursts();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule